// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes frames one byte at a time and stores them in a circular region of buffer memory. The buffer is split into 256-byte pages, and a page number is the upper byte of a memory address. The host sets three page numbers: the first page of the region, the page just past its end, and a boundary page. The boundary page marks the oldest page that the host has not yet freed. The block keeps a current-page pointer, and each new frame starts on that page. Each stored frame is led by a 4-byte header.

The payload goes in first, starting at byte offset 4 of the current page. When the write address runs off the last page of the region, it wraps back to the first page. The header is written only after the frame has ended. It holds a status byte, the page where the next frame will begin, and the stored length, which is the payload length plus 4, low byte first. After the header is written, the current-page pointer moves to that next page and a flag is raised.

A frame is dropped, and the overwrite-warning flag is raised, if storing it would claim the boundary page. A frame that ends with an error is dropped unless keeping errored frames is enabled. Each of the three sticky flags has its own interrupt enable bit.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `cur_pg` is 0, `irq_flags` is 0, `irq` is 0 and `mem_we` is 0.
- R2: The first payload byte of a frame is written at page `cur_pg`, offset 4. Each following byte is written at the next address.
- R3: After offset 255 of page `ring_stop_pg-1`, the next byte is written at offset 0 of page `ring_first_pg`. Any other page P, when exhausted, is followed by page P+1.
- R4: Header byte 0, at offset 0 of the frame's first page, is the status byte. Bit 0 means no error, bit 1 is CRC error, bit 2 is alignment error, bit 3 is FIFO overrun, and bits 7:4 are zero. The error inputs are sampled with the end-of-frame byte.
- R5: Header byte 1 is the page that follows, in wrapped order, the page holding the frame's last byte.
- R6: Header bytes 2 and 3 hold payload length + 4, low byte at offset 2 and high byte at offset 3.
- R7: Once the header is written, `cur_pg` takes the value from R5. A kept frame sets flag bit 0 (received) if it had no error, or flag bit 1 (error) if it had one.
- R8: If a frame's bytes would move into a page equal to `bound_pg`, the frame is dropped. No header is written, `cur_pg` is unchanged, and flag bit 2 (overwrite) is set.
- R9: If the page from R5 equals `bound_pg`, the frame is dropped in the same way, with flag bit 2 set.
- R10: A frame with any error bit set is dropped when `keep_bad` is 0: no header is written, `cur_pg` is unchanged, and flag bit 1 is set. When `keep_bad` is 1, the frame is stored according to R4 to R7.
- R11: Flags stay set until a 1 is written to the matching bit of `flag_clr`. `irq` is the OR of `irq_flags & irq_mask`.
- R12: A pulse on `cur_set` loads `cur_set_pg` into `cur_pg`.
- R13: While no frame is in progress, a valid byte that does not carry `fr_sof` causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_first_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring |
| bound_pg | input | 8 | Oldest page the host still holds |
| keep_bad | input | 1 | Store frames that end with an error |
| irq_mask | input | 3 | Interrupt enables for flag bits 0..2 |
| flag_clr | input | 3 | Write 1 to clear the matching flag |
| cur_set | input | 1 | Load the current-page pointer |
| cur_set_pg | input | 8 | Value loaded by cur_set |
| fr_valid | input | 1 | Frame byte valid |
| fr_sof | input | 1 | First byte of a frame |
| fr_eof | input | 1 | Last byte of a frame |
| fr_data | input | 8 | Frame byte |
| fr_crc_err | input | 1 | CRC error, valid with fr_eof |
| fr_align_err | input | 1 | Alignment error, valid with fr_eof |
| fr_fifo_err | input | 1 | FIFO overrun, valid with fr_eof |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_addr | output | 16 | Buffer RAM byte address |
| mem_wdata | output | 8 | Buffer RAM write data |
| cur_pg | output | 8 | Current-page pointer |
| irq_flags | output | 3 | Sticky flags: received, error, overwrite |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench runs frame lengths 1 to 300 and 508 to 516 back to back over a four-page ring. These lengths cover single-page frames, frames that end exactly on a page's last byte, and frames that spill into a following page. Because the current page rotates from frame to frame, the same lengths also land across the wrap from the last page to the first, which separates correct wrapping from plain page increments. The boundary is placed either one or two pages ahead, which separates an overflow found while the payload is being written from one found only when the next-page link is computed. Error frames with `keep_bad` both clear and set separate dropping from storing, and mask patterns show which flags reach `irq`.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } rxr_state_e;

    localparam int NFLAG   = 3;
    localparam int FLG_OK  = 0;
    localparam int FLG_ERR = 1;
    localparam int FLG_OVW = 2;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] pg,
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] stop_pg,
    output logic [PG_W-1:0] nxt_pg
);
    logic [PG_W-1:0] inc;

    always_comb begin
        inc    = pg + PG_W'(1);
        nxt_pg = (inc == stop_pg) ? first_pg : inc;
    end
endmodule

// File: rtl/rxr_status_enc.sv
module rxr_status_enc (
    input  logic       crc_err,
    input  logic       align_err,
    input  logic       fifo_err,
    output logic       any_err,
    output logic [7:0] stat
);
    always_comb begin
        any_err = crc_err | align_err | fifo_err;
        stat    = {4'b0000, fifo_err, align_err, crc_err, ~any_err};
    end
endmodule

// File: rtl/rxr_irq_flags.sv
module rxr_irq_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] mask,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] flags_d, flags_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_comb begin
            flags_d[i] = set[i] ? 1'b1 : (clr[i] ? 1'b0 : flags_q[i]);
        end
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= flags_d[i];
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & mask);
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
    parameter int PG_W  = 8,
    parameter int OFS_W = 8,
    parameter int LEN_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PG_W-1:0]           ring_first_pg,
    input  logic [PG_W-1:0]           ring_stop_pg,
    input  logic [PG_W-1:0]           bound_pg,
    input  logic                      keep_bad,
    input  logic [rxr_pkg::NFLAG-1:0] irq_mask,
    input  logic [rxr_pkg::NFLAG-1:0] flag_clr,
    input  logic                      cur_set,
    input  logic [PG_W-1:0]           cur_set_pg,
    input  logic                      fr_valid,
    input  logic                      fr_sof,
    input  logic                      fr_eof,
    input  logic [7:0]                fr_data,
    input  logic                      fr_crc_err,
    input  logic                      fr_align_err,
    input  logic                      fr_fifo_err,
    output logic                      mem_we,
    output logic [PG_W+OFS_W-1:0]     mem_addr,
    output logic [7:0]                mem_wdata,
    output logic [PG_W-1:0]           cur_pg,
    output logic [rxr_pkg::NFLAG-1:0] irq_flags,
    output logic                      irq
);
    import rxr_pkg::*;

    localparam int AW      = PG_W + OFS_W;
    localparam int HDR_LEN = 4;
    localparam int HIDX_W  = $clog2(HDR_LEN);

    typedef struct packed {
        rxr_state_e       st;
        logic [AW-1:0]    wa;
        logic [LEN_W-1:0] len;
        logic [HIDX_W-1:0] hidx;
        logic [PG_W-1:0]  nxt;
        logic [7:0]       stat;
        logic [PG_W-1:0]  cur;
        logic             we;
        logic [AW-1:0]    addr;
        logic [7:0]       wd;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]    byte_addr;
    logic [PG_W-1:0]  step_pg;
    logic             pg_end;
    logic [AW-1:0]    addr_inc;
    logic [LEN_W-1:0] len_base;
    logic [LEN_W-1:0] hdr_cnt;
    logic             any_err;
    logic [7:0]       stat_now;
    logic [NFLAG-1:0] flag_set;

    // Byte address of the incoming byte: fresh frames start past the header.
    assign byte_addr = (r_q.st == ST_IDLE) ? {r_q.cur, OFS_W'(HDR_LEN)} : r_q.wa;
    assign pg_end    = &byte_addr[OFS_W-1:0];
    assign addr_inc  = pg_end ? {step_pg, {OFS_W{1'b0}}} : byte_addr + AW'(1);
    assign len_base  = (r_q.st == ST_IDLE) ? '0 : r_q.len;
    assign hdr_cnt   = r_q.len + LEN_W'(HDR_LEN);

    rxr_page_step #(.PG_W(PG_W)) u_step (
        .pg       (byte_addr[AW-1:OFS_W]),
        .first_pg (ring_first_pg),
        .stop_pg  (ring_stop_pg),
        .nxt_pg   (step_pg)
    );

    rxr_status_enc u_stat (
        .crc_err   (fr_crc_err),
        .align_err (fr_align_err),
        .fifo_err  (fr_fifo_err),
        .any_err   (any_err),
        .stat      (stat_now)
    );

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        flag_set = '0;

        if (cur_set) r_d.cur = cur_set_pg;

        unique case (r_q.st)
            ST_IDLE, ST_DATA: begin
                if (fr_valid && (fr_sof || r_q.st == ST_DATA)) begin
                    r_d.we   = 1'b1;
                    r_d.addr = byte_addr;
                    r_d.wd   = fr_data;
                    r_d.len  = len_base + LEN_W'(1);
                    if (fr_eof) begin
                        if (step_pg == bound_pg) begin
                            flag_set[FLG_OVW] = 1'b1;
                            r_d.st            = ST_IDLE;
                        end else if (any_err && !keep_bad) begin
                            flag_set[FLG_ERR] = 1'b1;
                            r_d.st            = ST_IDLE;
                        end else begin
                            r_d.st   = ST_HDR;
                            r_d.hidx = '0;
                            r_d.nxt  = step_pg;
                            r_d.stat = stat_now;
                        end
                    end else if (pg_end && step_pg == bound_pg) begin
                        flag_set[FLG_OVW] = 1'b1;
                        r_d.st            = ST_DROP;
                    end else begin
                        r_d.st = ST_DATA;
                        r_d.wa = addr_inc;
                    end
                end
            end
            ST_DROP: begin
                if (fr_valid && fr_eof) r_d.st = ST_IDLE;
            end
            ST_HDR: begin
                r_d.we   = 1'b1;
                r_d.addr = {r_q.cur[PG_W-1:0], OFS_W'(r_q.hidx)};
                case (r_q.hidx)
                    2'd0:    r_d.wd = r_q.stat;
                    2'd1:    r_d.wd = 8'(r_q.nxt);
                    2'd2:    r_d.wd = hdr_cnt[7:0];
                    default: r_d.wd = hdr_cnt[15:8];
                endcase
                r_d.hidx = r_q.hidx + HIDX_W'(1);
                if (r_q.hidx == HIDX_W'(HDR_LEN - 1)) begin
                    r_d.cur = r_q.nxt;
                    r_d.st  = ST_IDLE;
                    if (r_q.stat[0]) flag_set[FLG_OK]  = 1'b1;
                    else             flag_set[FLG_ERR] = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    rxr_irq_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .mask  (irq_mask),
        .flags (irq_flags),
        .irq   (irq)
    );

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wd;
    assign cur_pg    = r_q.cur;
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
    parameter int PG_W  = 8,
    parameter int OFS_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [PG_W-1:0]       ring_first_pg,
    input logic [PG_W-1:0]       ring_stop_pg,
    input logic                  cur_set,
    input logic [2:0]            flag_clr,
    input logic                  mem_we,
    input logic [PG_W+OFS_W-1:0] mem_addr,
    input logic [PG_W-1:0]       cur_pg,
    input logic [2:0]            irq_flags
);
    localparam int AW = PG_W + OFS_W;

    // R3
    ring_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ring_first_pg < ring_stop_pg && cur_pg >= ring_first_pg && cur_pg < ring_stop_pg)
        |-> (mem_addr[AW-1:OFS_W] >= ring_first_pg && mem_addr[AW-1:OFS_W] < ring_stop_pg));

    // R7
    cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cur_set) && cur_pg != $past(cur_pg))
        |-> (mem_we && mem_addr[OFS_W-1:0] == OFS_W'(3)));

    // R7
    ok_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[0]) |-> (mem_we && mem_addr[OFS_W-1:0] == OFS_W'(3)));

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_flags) & ~irq_flags & ~$past(flag_clr)) == 3'b000));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.PG_W(PG_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_first_pg (ring_first_pg),
    .ring_stop_pg  (ring_stop_pg),
    .cur_set       (cur_set),
    .flag_clr      (flag_clr),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .cur_pg        (cur_pg),
    .irq_flags     (irq_flags)
);

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FIRST = 8'h40;
    localparam int STOP  = 8'h44;
    localparam int NRING = STOP - FIRST;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] ring_first_pg = 8'(FIRST);
    logic [7:0] ring_stop_pg  = 8'(STOP);
    logic [7:0] bound_pg = 8'h00;
    logic keep_bad = 1'b0;
    logic [2:0] irq_mask = 3'b000;
    logic [2:0] flag_clr = 3'b000;
    logic cur_set = 1'b0;
    logic [7:0] cur_set_pg = 8'h00;
    logic fr_valid = 1'b0, fr_sof = 1'b0, fr_eof = 1'b0;
    logic [7:0] fr_data = 8'h00;
    logic fr_crc_err = 1'b0, fr_align_err = 1'b0, fr_fifo_err = 1'b0;
    logic mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] cur_pg;
    logic [2:0] irq_flags;
    logic irq;

    int n_chk = 0, n_bad = 0, wcount = 0, cyc = 0, exp_cur = 0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_ring_writer u_dut (.*);

    always @(posedge clk) begin
        cyc++;
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wcount++;
        end
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int wadd(int p, int k);
        return FIRST + ((p - FIRST + k) % NRING);
    endfunction

    function automatic int rd(int a);
        return mem.exists(a) ? int'(mem[a]) : -1;
    endfunction

    task automatic clear_flags();
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
    endtask

    task automatic send(int len, bit crc, bit aln, bit ff, int seed);
        for (int i = 0; i < len; i++) begin
            fr_valid = 1'b1;
            fr_sof = (i == 0);
            fr_eof = (i == len - 1);
            fr_data = 8'(i * 7 + seed);
            fr_crc_err = crc && (i == len - 1);
            fr_align_err = aln && (i == len - 1);
            fr_fifo_err = ff && (i == len - 1);
            @(negedge clk);
        end
        fr_valid = 1'b0; fr_sof = 1'b0; fr_eof = 1'b0;
        fr_crc_err = 1'b0; fr_align_err = 1'b0; fr_fifo_err = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_frame(int len, bit crc, bit aln, bit ff, int seed);
        int npg, nxt, badp, bad, cur0, stat, pos, pg;
        bit mid_ovw;
        cur0 = exp_cur;
        mem.delete();
        clear_flags();
        send(len, crc, aln, ff, seed);
        npg = (len + 4 + 255) / 256;
        mid_ovw = 1'b0;
        for (int k = 1; k < npg; k++) if (wadd(cur0, k) == int'(bound_pg)) mid_ovw = 1'b1;
        nxt = wadd(cur0, npg);
        bad = int'(crc | aln | ff);
        if (mid_ovw) begin
            check("R8 cur_pg kept", int'(cur_pg), cur0);
            check("R8 flags", int'(irq_flags), 4);
            check("R8 no header", rd(cur0 * 256), -1);
        end else if (nxt == int'(bound_pg)) begin
            check("R9 cur_pg kept", int'(cur_pg), cur0);
            check("R9 flags", int'(irq_flags), 4);
            check("R9 no header", rd(cur0 * 256), -1);
        end else if (bad != 0 && !keep_bad) begin
            check("R10 cur_pg kept", int'(cur_pg), cur0);
            check("R10 flags", int'(irq_flags), 2);
            check("R10 no header", rd(cur0 * 256 + 3), -1);
        end else begin
            stat = (int'(ff) << 3) | (int'(aln) << 2) | (int'(crc) << 1) | (bad == 0 ? 1 : 0);
            check("R4 status byte", rd(cur0 * 256), stat);
            check("R5 next page", rd(cur0 * 256 + 1), nxt);
            check("R6 count low", rd(cur0 * 256 + 2), (len + 4) & 255);
            check("R6 count high", rd(cur0 * 256 + 3), (len + 4) >> 8);
            badp = 0;
            for (int i = 0; i < len; i++) begin
                pos = 4 + i;
                pg = wadd(cur0, pos / 256);
                if (rd(pg * 256 + pos % 256) != ((i * 7 + seed) & 255)) badp++;
            end
            // R2 R3: payload placement with page wrap
            check("R2 R3 payload mismatches", badp, 0);
            check("R7 cur_pg advanced", int'(cur_pg), nxt);
            check("R7 flags", int'(irq_flags), bad != 0 ? 2 : 1);
            exp_cur = nxt;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cur_pg", int'(cur_pg), 0);
        check("R1 flags", int'(irq_flags), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: load current page
        cur_set = 1'b1; cur_set_pg = 8'(FIRST);
        @(negedge clk);
        cur_set = 1'b0;
        check("R12 cur_pg loaded", int'(cur_pg), FIRST);
        exp_cur = FIRST;

        // R13: bytes without sof while idle
        wcount = 0;
        for (int i = 0; i < 5; i++) begin
            fr_valid = 1'b1; fr_data = 8'(i); fr_eof = (i == 4);
            @(negedge clk);
        end
        fr_valid = 1'b0; fr_eof = 1'b0;
        repeat (6) @(negedge clk);
        check("R13 no writes", wcount, 0);
        check("R13 cur_pg", int'(cur_pg), FIRST);

        // Length sweep, boundary right at the current page (everything freed)
        for (int l = 1; l <= 300; l++) begin
            bound_pg = 8'(exp_cur);
            run_frame(l, 1'b0, 1'b0, 1'b0, l);
        end
        for (int l = 508; l <= 516; l++) begin
            bound_pg = 8'(exp_cur);
            run_frame(l, 1'b0, 1'b0, 1'b0, l);
        end

        // R8: overflow while payload is written
        bound_pg = 8'(wadd(exp_cur, 2));
        run_frame(600, 1'b0, 1'b0, 1'b0, 3);
        // R9: overflow on next-page link
        bound_pg = 8'(wadd(exp_cur, 1));
        run_frame(100, 1'b0, 1'b0, 1'b0, 5);
        run_frame(252, 1'b0, 1'b0, 1'b0, 6);
        bound_pg = 8'(wadd(exp_cur, 2));
        run_frame(252, 1'b0, 1'b0, 1'b0, 7);

        // R10: errored frames
        bound_pg = 8'(exp_cur);
        keep_bad = 1'b0;
        run_frame(40, 1'b1, 1'b0, 1'b0, 9);
        run_frame(40, 1'b0, 1'b1, 1'b1, 10);
        keep_bad = 1'b1;
        bound_pg = 8'(exp_cur);
        run_frame(40, 1'b0, 1'b1, 1'b0, 11);
        bound_pg = 8'(exp_cur);
        run_frame(300, 1'b1, 1'b0, 1'b1, 12);
        keep_bad = 1'b0;

        // R11: masking and clearing
        bound_pg = 8'(exp_cur);
        run_frame(20, 1'b0, 1'b0, 1'b0, 13);
        irq_mask = 3'b001; #1;
        check("R11 irq enabled flag", int'(irq), 1);
        irq_mask = 3'b110; #1;
        check("R11 irq masked flag", int'(irq), 0);
        bound_pg = 8'(exp_cur);
        keep_bad = 1'b0;
        send(30, 1'b1, 1'b0, 1'b0, 14);
        check("R11 flags accumulate", int'(irq_flags), 3);
        check("R11 irq on error", int'(irq), 1);
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        check("R11 partial clear", int'(irq_flags), 1);
        check("R11 irq after clear", int'(irq), 0);
        @(negedge clk);
        check("R11 flag stays", int'(irq_flags), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule